// File: doc/BRIEF.md
# Multi-Channel Event Fragment Builder

This block collects the pieces of one event from up to eight input channels and sends them out as a single framed fragment on a 32-bit valid/ready stream. Each channel feeds it through two first-word-fall-through FIFOs: one holds a length entry per event, the other holds the data words. A third FIFO supplies trigger information: event number, bunch crossing number and trigger type. The builder reads all of these FIFOs directly, through an empty flag and a read strobe for each one.

For every trigger entry the builder sends an eleven-word header. It then walks the enabled channels from the lowest index to the highest. For each one it takes a length entry and copies that many data words. It closes each channel with a link word that carries the channel number and its word count. A six-word trailer ends the fragment; it carries the number of words sent between header and trailer. Static inputs supply the format version, module identifier, run number and detector event type. A test mode takes the event number from an internal fragment counter, so the block can run with no trigger source.

Top module: `evb_builder`

## Requirements
- R1: A fragment opens with 11 header words in this order: 0xB0F00000, 0xEE1234EE, 0x00000009, cfg_format_ver, cfg_module_id, cfg_run_num, event word {0x00, event[23:0]}, {20'h0, bunch[11:0]}, {24'h0, type[7:0]}, {16'h0, cfg_det_type}, block-start word {0x80, event[23:0]}.
- R2: With cfg_test_mode low when the trigger entry is taken, the event number in header words 6 and 10 is trg_event_id of that entry.
- R3: With cfg_test_mode high when the trigger entry is taken, the event number is the internal fragment counter. The counter is 0 after reset and rises by one for each completed fragment, in either mode.
- R4: Channels are visited in ascending index order, and only those whose bit is set in cfg_chan_en. The mask is sampled when the trigger entry is taken. The length FIFO of a disabled channel is never read.
- R5: For each enabled channel the builder pops exactly one length entry L. It then forwards exactly L words from that channel's data FIFO, unchanged and in order. It then sends the link word {4'hA, channel[3:0], 8'h00, L[15:0]}.
- R6: The fragment ends with 6 trailer words: {16'hF000, W}, 0x00000000, 0x00000001, {16'h0, W}, 0x00000001, 0xE0F00000.
- R7: W in trailer words 0 and 3 equals the number of words sent between the last header word and the first trailer word (data words plus link words).
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value in the next cycle. A data FIFO is popped only in a cycle where a word is accepted.
- R9: Nothing is sent and no channel FIFO is popped until the trigger FIFO is non-empty. If an enabled channel's length FIFO is empty, the builder waits with out_valid low.
- R10: A length entry of 0 produces only the link word for that channel, with a count field of 0.
- R11: While in reset and right after it, out_valid, trg_rd, len_rd and dat_rd are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trg_empty | input | 1 | Trigger FIFO empty flag |
| trg_rd | output | 1 | Trigger FIFO read strobe |
| trg_event_id | input | EVID_W | Event number at trigger FIFO head |
| trg_bcid | input | BC_W | Bunch number at trigger FIFO head |
| trg_type | input | TT_W | Trigger type at trigger FIFO head |
| len_empty | input | N_CH | Per-channel length FIFO empty flags |
| len_data | input | N_CH*LEN_W | Per-channel length FIFO heads, channel 0 in the low bits |
| len_rd | output | N_CH | Per-channel length FIFO read strobes |
| dat_empty | input | N_CH | Per-channel data FIFO empty flags |
| dat_data | input | N_CH*32 | Per-channel data FIFO heads, channel 0 in the low bits |
| dat_rd | output | N_CH | Per-channel data FIFO read strobes |
| cfg_chan_en | input | N_CH | Channel enable mask |
| cfg_test_mode | input | 1 | Take the event number from the internal counter |
| cfg_format_ver | input | 32 | Format version header word |
| cfg_module_id | input | 32 | Module identifier header word |
| cfg_run_num | input | 32 | Run number header word |
| cfg_det_type | input | DET_W | Detector event type |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| out_ready | input | 1 | Downstream accepts the word |

## Verification
Two things can happen in the same cycle: output back-pressure, and the hand-off from one channel to the next or from the last word to the trailer. Back-pressure can hold the last data word of a channel, or a link word, at the very cycle the sequencer would step ahead. A pseudo-random out_ready stalls about a quarter of all cycles and runs through every enable mask, with lengths from 0 to 4. This places stalls on data, link, header and trailer words alike. Each accepted word is compared with a stream the bench builds arithmetically from the mask and lengths. Any word still on the output during a stall must equal the one seen in the cycle before.

// File: rtl/evb_pkg.sv
package evb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_SCAN,
      ST_LEN,
      ST_DATA,
      ST_LCNT,
      ST_TRL
   } evb_state_e;

   localparam int HDR_WORDS = 11;
   localparam int TRL_WORDS = 6;

   localparam logic [31:0] W_BOF    = 32'hB0F0_0000;
   localparam logic [31:0] W_HMARK  = 32'hEE12_34EE;
   localparam logic [31:0] W_HSIZE  = 32'h0000_0009;
   localparam logic [31:0] W_STATUS = 32'h0000_0000;
   localparam logic [31:0] W_NSTAT  = 32'h0000_0001;
   localparam logic [31:0] W_SPOS   = 32'h0000_0001;
   localparam logic [31:0] W_EOF    = 32'hE0F0_0000;
   localparam logic [7:0]  TAG_BLK  = 8'h80;
   localparam logic [15:0] TAG_EOB  = 16'hF000;
   localparam logic [3:0]  TAG_LINK = 4'hA;

endpackage

// File: rtl/evb_frame_rom.sv
module evb_frame_rom
   import evb_pkg::*;
#(
   parameter int EVID_W = 24,
   parameter int BC_W   = 12,
   parameter int TT_W   = 8,
   parameter int DET_W  = 16,
   parameter int WC_W   = 16
) (
   input  logic              is_trl,
   input  logic [3:0]        idx,
   input  logic [31:0]       fmt_ver,
   input  logic [31:0]       module_id,
   input  logic [31:0]       run_num,
   input  logic [EVID_W-1:0] evid,
   input  logic [BC_W-1:0]   bcid,
   input  logic [TT_W-1:0]   ttype,
   input  logic [DET_W-1:0]  det_type,
   input  logic [WC_W-1:0]   wcnt,
   output logic [31:0]       word
);

   logic [23:0] evid24;
   logic [15:0] wc16;

   assign evid24 = 24'(evid);
   assign wc16   = 16'(wcnt);

   always_comb begin
      word = '0;
      if (!is_trl) begin
         case (idx)
            4'd0:    word = W_BOF;
            4'd1:    word = W_HMARK;
            4'd2:    word = W_HSIZE;
            4'd3:    word = fmt_ver;
            4'd4:    word = module_id;
            4'd5:    word = run_num;
            4'd6:    word = {8'h00, evid24};
            4'd7:    word = 32'(bcid);
            4'd8:    word = 32'(ttype);
            4'd9:    word = 32'(det_type);
            4'd10:   word = {TAG_BLK, evid24};
            default: word = '0;
         endcase
      end else begin
         case (idx)
            4'd0:    word = {TAG_EOB, wc16};
            4'd1:    word = W_STATUS;
            4'd2:    word = W_NSTAT;
            4'd3:    word = {16'h0000, wc16};
            4'd4:    word = W_SPOS;
            4'd5:    word = W_EOF;
            default: word = '0;
         endcase
      end
   end

endmodule

// File: rtl/evb_chan_sel.sv
module evb_chan_sel #(
   parameter int N_CH  = 8,
   parameter int CH_W  = 3,
   parameter int LEN_W = 12,
   parameter int DW    = 32
) (
   input  logic [CH_W-1:0]       ch,
   input  logic [N_CH-1:0]       len_empty,
   input  logic [N_CH*LEN_W-1:0] len_data,
   input  logic [N_CH-1:0]       dat_empty,
   input  logic [N_CH*DW-1:0]    dat_data,
   input  logic                  len_pop,
   input  logic                  dat_pop,
   output logic                  sel_len_empty,
   output logic [LEN_W-1:0]      sel_len,
   output logic                  sel_dat_empty,
   output logic [DW-1:0]         sel_dat,
   output logic [N_CH-1:0]       len_rd,
   output logic [N_CH-1:0]       dat_rd
);

   logic [LEN_W-1:0] len_arr [N_CH];
   logic [DW-1:0]    dat_arr [N_CH];

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      assign len_arr[i] = len_data[i*LEN_W +: LEN_W];
      assign dat_arr[i] = dat_data[i*DW +: DW];
      assign len_rd[i]  = len_pop && (ch == CH_W'(i));
      assign dat_rd[i]  = dat_pop && (ch == CH_W'(i));
   end

   assign sel_len_empty = len_empty[ch];
   assign sel_len       = len_arr[ch];
   assign sel_dat_empty = dat_empty[ch];
   assign sel_dat       = dat_arr[ch];

endmodule

// File: rtl/evb_seq.sv
module evb_seq
   import evb_pkg::*;
#(
   parameter int N_CH   = 8,
   parameter int CH_W   = 3,
   parameter int LEN_W  = 12,
   parameter int EVID_W = 24,
   parameter int BC_W   = 12,
   parameter int TT_W   = 8,
   parameter int WC_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trg_empty,
   input  logic [EVID_W-1:0] trg_event_id,
   input  logic [BC_W-1:0]   trg_bcid,
   input  logic [TT_W-1:0]   trg_type,
   input  logic [N_CH-1:0]   cfg_chan_en,
   input  logic              cfg_test_mode,
   input  logic              sel_len_empty,
   input  logic [LEN_W-1:0]  sel_len,
   input  logic              sel_dat_empty,
   input  logic              out_ready,
   output logic              trg_rd,
   output logic              len_pop,
   output logic              dat_pop,
   output logic              out_valid,
   output evb_state_e        state,
   output logic [3:0]        idx,
   output logic [CH_W-1:0]   ch,
   output logic [LEN_W-1:0]  len_q,
   output logic [WC_W-1:0]   wcnt,
   output logic [EVID_W-1:0] evid_q,
   output logic [BC_W-1:0]   bcid_q,
   output logic [TT_W-1:0]   type_q
);

   localparam logic [CH_W-1:0] CH_LAST  = CH_W'(N_CH - 1);
   localparam logic [3:0]      HDR_LAST = 4'(HDR_WORDS - 1);
   localparam logic [3:0]      TRL_LAST = 4'(TRL_WORDS - 1);

   logic [N_CH-1:0]   en_q;
   logic [LEN_W-1:0]  rem;
   logic [EVID_W-1:0] tcnt;
   logic              fire;

   always_comb begin
      case (state)
         ST_HDR, ST_TRL, ST_LCNT: out_valid = 1'b1;
         ST_DATA:                 out_valid = !sel_dat_empty;
         default:                 out_valid = 1'b0;
      endcase
   end

   assign fire    = out_valid && out_ready;
   assign trg_rd  = (state == ST_IDLE) && !trg_empty;
   assign len_pop = (state == ST_LEN) && !sel_len_empty;
   assign dat_pop = (state == ST_DATA) && fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         idx    <= '0;
         ch     <= '0;
         en_q   <= '0;
         rem    <= '0;
         len_q  <= '0;
         wcnt   <= '0;
         tcnt   <= '0;
         evid_q <= '0;
         bcid_q <= '0;
         type_q <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (trg_rd) begin
                  evid_q <= cfg_test_mode ? tcnt : trg_event_id;
                  bcid_q <= trg_bcid;
                  type_q <= trg_type;
                  en_q   <= cfg_chan_en;
                  idx    <= '0;
                  wcnt   <= '0;
                  state  <= ST_HDR;
               end
            end
            ST_HDR: begin
               if (fire) begin
                  if (idx == HDR_LAST) begin
                     ch    <= '0;
                     state <= ST_SCAN;
                  end else begin
                     idx <= idx + 4'd1;
                  end
               end
            end
            ST_SCAN: begin
               if (en_q[ch]) begin
                  state <= ST_LEN;
               end else if (ch == CH_LAST) begin
                  idx   <= '0;
                  state <= ST_TRL;
               end else begin
                  ch <= ch + CH_W'(1);
               end
            end
            ST_LEN: begin
               if (len_pop) begin
                  len_q <= sel_len;
                  rem   <= sel_len;
                  state <= (sel_len == '0) ? ST_LCNT : ST_DATA;
               end
            end
            ST_DATA: begin
               if (fire) begin
                  rem  <= rem - LEN_W'(1);
                  wcnt <= wcnt + WC_W'(1);
                  if (rem == LEN_W'(1)) state <= ST_LCNT;
               end
            end
            ST_LCNT: begin
               if (fire) begin
                  wcnt <= wcnt + WC_W'(1);
                  if (ch == CH_LAST) begin
                     idx   <= '0;
                     state <= ST_TRL;
                  end else begin
                     ch    <= ch + CH_W'(1);
                     state <= ST_SCAN;
                  end
               end
            end
            ST_TRL: begin
               if (fire) begin
                  if (idx == TRL_LAST) begin
                     tcnt  <= tcnt + EVID_W'(1);
                     state <= ST_IDLE;
                  end else begin
                     idx <= idx + 4'd1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/evb_builder.sv
module evb_builder
   import evb_pkg::*;
#(
   parameter int N_CH   = 8,
   parameter int LEN_W  = 12,
   parameter int EVID_W = 24,
   parameter int BC_W   = 12,
   parameter int TT_W   = 8,
   parameter int DET_W  = 16,
   parameter int WC_W   = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  trg_empty,
   output logic                  trg_rd,
   input  logic [EVID_W-1:0]     trg_event_id,
   input  logic [BC_W-1:0]       trg_bcid,
   input  logic [TT_W-1:0]       trg_type,
   input  logic [N_CH-1:0]       len_empty,
   input  logic [N_CH*LEN_W-1:0] len_data,
   output logic [N_CH-1:0]       len_rd,
   input  logic [N_CH-1:0]       dat_empty,
   input  logic [N_CH*32-1:0]    dat_data,
   output logic [N_CH-1:0]       dat_rd,
   input  logic [N_CH-1:0]       cfg_chan_en,
   input  logic                  cfg_test_mode,
   input  logic [31:0]           cfg_format_ver,
   input  logic [31:0]           cfg_module_id,
   input  logic [31:0]           cfg_run_num,
   input  logic [DET_W-1:0]      cfg_det_type,
   output logic                  out_valid,
   output logic [31:0]           out_data,
   input  logic                  out_ready
);

   localparam int DW   = 32;
   localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

   if (N_CH < 1 || N_CH > 16) begin : g_bad_nch
      $error("evb_builder: N_CH must be 1..16");
   end
   if (LEN_W < 1 || LEN_W > WC_W) begin : g_bad_len
      $error("evb_builder: LEN_W must be 1..WC_W");
   end
   if (WC_W != 16) begin : g_bad_wc
      $error("evb_builder: WC_W must be 16");
   end
   if (EVID_W < 1 || EVID_W > 24) begin : g_bad_evid
      $error("evb_builder: EVID_W must be 1..24");
   end
   if (BC_W > 32 || TT_W > 32 || DET_W > 32) begin : g_bad_fld
      $error("evb_builder: field wider than a word");
   end

   evb_state_e        state;
   logic [3:0]        idx;
   logic [CH_W-1:0]   ch;
   logic [LEN_W-1:0]  len_q;
   logic [WC_W-1:0]   wcnt;
   logic [EVID_W-1:0] evid_q;
   logic [BC_W-1:0]   bcid_q;
   logic [TT_W-1:0]   type_q;
   logic              sel_len_empty;
   logic [LEN_W-1:0]  sel_len;
   logic              sel_dat_empty;
   logic [DW-1:0]     sel_dat;
   logic              len_pop;
   logic              dat_pop;
   logic [31:0]       frame_word;
   logic [31:0]       link_word;

   evb_seq #(
      .N_CH(N_CH), .CH_W(CH_W), .LEN_W(LEN_W), .EVID_W(EVID_W),
      .BC_W(BC_W), .TT_W(TT_W), .WC_W(WC_W)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .trg_empty     (trg_empty),
      .trg_event_id  (trg_event_id),
      .trg_bcid      (trg_bcid),
      .trg_type      (trg_type),
      .cfg_chan_en   (cfg_chan_en),
      .cfg_test_mode (cfg_test_mode),
      .sel_len_empty (sel_len_empty),
      .sel_len       (sel_len),
      .sel_dat_empty (sel_dat_empty),
      .out_ready     (out_ready),
      .trg_rd        (trg_rd),
      .len_pop       (len_pop),
      .dat_pop       (dat_pop),
      .out_valid     (out_valid),
      .state         (state),
      .idx           (idx),
      .ch            (ch),
      .len_q         (len_q),
      .wcnt          (wcnt),
      .evid_q        (evid_q),
      .bcid_q        (bcid_q),
      .type_q        (type_q)
   );

   evb_chan_sel #(
      .N_CH(N_CH), .CH_W(CH_W), .LEN_W(LEN_W), .DW(DW)
   ) u_sel (
      .ch            (ch),
      .len_empty     (len_empty),
      .len_data      (len_data),
      .dat_empty     (dat_empty),
      .dat_data      (dat_data),
      .len_pop       (len_pop),
      .dat_pop       (dat_pop),
      .sel_len_empty (sel_len_empty),
      .sel_len       (sel_len),
      .sel_dat_empty (sel_dat_empty),
      .sel_dat       (sel_dat),
      .len_rd        (len_rd),
      .dat_rd        (dat_rd)
   );

   evb_frame_rom #(
      .EVID_W(EVID_W), .BC_W(BC_W), .TT_W(TT_W), .DET_W(DET_W), .WC_W(WC_W)
   ) u_rom (
      .is_trl    (state == ST_TRL),
      .idx       (idx),
      .fmt_ver   (cfg_format_ver),
      .module_id (cfg_module_id),
      .run_num   (cfg_run_num),
      .evid      (evid_q),
      .bcid      (bcid_q),
      .ttype     (type_q),
      .det_type  (cfg_det_type),
      .wcnt      (wcnt),
      .word      (frame_word)
   );

   assign link_word = {TAG_LINK, 4'(ch), 8'h00, 16'(len_q)};

   always_comb begin
      case (state)
         ST_DATA:        out_data = sel_dat;
         ST_LCNT:        out_data = link_word;
         ST_HDR, ST_TRL: out_data = frame_word;
         default:        out_data = '0;
      endcase
   end

endmodule

// File: rtl/evb_chk.sv
module evb_chk #(
   parameter int N_CH = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            trg_empty,
   input logic            trg_rd,
   input logic [N_CH-1:0] len_empty,
   input logic [N_CH-1:0] len_rd,
   input logic [N_CH-1:0] dat_rd,
   input logic [N_CH-1:0] cfg_chan_en,
   input logic            out_valid,
   input logic [31:0]     out_data,
   input logic            out_ready
);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
      else $error("p_hold_r8");

   p_pop_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|dat_rd) |-> (out_valid && out_ready))
      else $error("p_pop_on_accept_r8");

   p_single_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dat_rd) && $onehot0(len_rd))
      else $error("p_single_pop_r5");

   p_len_not_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|len_rd) |-> ((len_rd & len_empty) == '0))
      else $error("p_len_not_empty_r5");

   p_skip_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|len_rd) |-> ((len_rd & ~cfg_chan_en) == '0))
      else $error("p_skip_disabled_r4");

   p_trg_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trg_rd |-> !trg_empty)
      else $error("p_trg_wait_r9");

   p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && !trg_rd && len_rd == '0 && dat_rd == '0))
      else $error("p_reset_quiet_r11");

endmodule

bind evb_builder evb_chk #(.N_CH(N_CH)) u_evb_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .trg_empty   (trg_empty),
   .trg_rd      (trg_rd),
   .len_empty   (len_empty),
   .len_rd      (len_rd),
   .dat_rd      (dat_rd),
   .cfg_chan_en (cfg_chan_en),
   .out_valid   (out_valid),
   .out_data    (out_data),
   .out_ready   (out_ready)
);

// File: tb/evb_builder_tb_top.sv
module evb_builder_tb_top;

   localparam int N  = 8;
   localparam int LW = 12;
   localparam int EXP_MAX = 16384;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            trg_empty;
   logic            trg_rd;
   logic [23:0]     trg_event_id = '0;
   logic [11:0]     trg_bcid = '0;
   logic [7:0]      trg_type = '0;
   logic [N-1:0]    len_empty;
   logic [N*LW-1:0] len_data;
   logic [N-1:0]    len_rd;
   logic [N-1:0]    dat_empty;
   logic [N*32-1:0] dat_data;
   logic [N-1:0]    dat_rd;
   logic [N-1:0]    cfg_chan_en = '0;
   logic            cfg_test_mode = 1'b0;
   logic [31:0]     cfg_format_ver = '0;
   logic [31:0]     cfg_module_id = '0;
   logic [31:0]     cfg_run_num = '0;
   logic [15:0]     cfg_det_type = '0;
   logic            out_valid;
   logic [31:0]     out_data;
   logic            out_ready = 1'b1;

   evb_builder dut_i (
      .clk(clk), .rst_n(rst_n),
      .trg_empty(trg_empty), .trg_rd(trg_rd),
      .trg_event_id(trg_event_id), .trg_bcid(trg_bcid), .trg_type(trg_type),
      .len_empty(len_empty), .len_data(len_data), .len_rd(len_rd),
      .dat_empty(dat_empty), .dat_data(dat_data), .dat_rd(dat_rd),
      .cfg_chan_en(cfg_chan_en), .cfg_test_mode(cfg_test_mode),
      .cfg_format_ver(cfg_format_ver), .cfg_module_id(cfg_module_id),
      .cfg_run_num(cfg_run_num), .cfg_det_type(cfg_det_type),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
   );

   // bench FIFO models: write side from tasks, read side from the pop process
   logic [LW-1:0] lmem [N][8];
   logic [31:0]   dmem [N][64];
   logic [3:0]    lwr [N];
   logic [3:0]    lrd [N];
   logic [6:0]    dwr [N];
   logic [6:0]    drd [N];
   int            trg_wr = 0;
   int            trg_rdc = 0;
   logic [N-1:0]  flush_mask = '0;

   initial begin
      for (int c = 0; c < N; c++) begin
         lwr[c] = '0;
         dwr[c] = '0;
      end
   end

   always_comb begin
      trg_empty = (trg_wr == trg_rdc);
      for (int c = 0; c < N; c++) begin
         len_empty[c]          = (lwr[c] == lrd[c]);
         len_data[c*LW +: LW]  = lmem[c][lrd[c][2:0]];
         dat_empty[c]          = (dwr[c] == drd[c]);
         dat_data[c*32 +: 32]  = dmem[c][drd[c][5:0]];
      end
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trg_rdc <= 0;
         for (int c = 0; c < N; c++) begin
            lrd[c] <= '0;
            drd[c] <= '0;
         end
      end else begin
         if (trg_rd) trg_rdc <= trg_rdc + 1;
         for (int c = 0; c < N; c++) begin
            if (flush_mask[c])  lrd[c] <= lwr[c];
            else if (len_rd[c]) lrd[c] <= lrd[c] + 4'd1;
            if (dat_rd[c])      drd[c] <= drd[c] + 7'd1;
         end
      end
   end

   // expected stream
   logic [31:0] exp_w   [EXP_MAX];
   int          exp_tag [EXP_MAX];
   int          exp_n = 0;
   int          got = 0;
   int          tests = 0;
   int          fails = 0;
   bit          done = 0;
   bit          col_en = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
      end
   endtask

   task automatic push_exp(input logic [31:0] w, input int tag);
      exp_w[exp_n]   = w;
      exp_tag[exp_n] = tag;
      exp_n++;
   endtask

   // collector and ready pattern at the falling edge
   logic [7:0]  lfsr = 8'hA5;
   bit          prev_stall = 0;
   logic [31:0] prev_data = '0;

   always @(negedge clk) begin
      lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0] | lfsr[1];
      if (rst_n && col_en) begin
         if (prev_stall)  // R8 held word
            chk(out_valid && out_data == prev_data, "R8", out_data, prev_data);
         if (out_valid && out_ready) begin
            if (got < exp_n) begin
               tests++;
               if (out_data !== exp_w[got]) begin
                  fails++;
                  $display("FAIL R%0d word %0d actual=%08h expected=%08h",
                           exp_tag[got], got, out_data, exp_w[got]);
               end
            end else begin
               chk(1'b0, "R9 unexpected word", out_data, 32'h0);
            end
            got++;
         end
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
      end
   end

   function automatic logic [LW-1:0] ch_len(input int e, input int c);
      return LW'((e + c * 3) % 5);
   endfunction

   task automatic load_chan(input int e, input int c);
      logic [LW-1:0] l;
      l = ch_len(e, c);
      lmem[c][lwr[c][2:0]] = l;
      lwr[c] = lwr[c] + 4'd1;
      for (int k = 0; k < int'(l); k++) begin
         dmem[c][dwr[c][5:0]] = {4'(c), 12'(e), 16'(k)};
         dwr[c] = dwr[c] + 7'd1;
      end
   endtask

   task automatic run_event(input int e);
      logic [7:0]  mask;
      bit          tmode, decoy, delayed;
      logic [23:0] evid;
      logic [15:0] w;
      int          base;
      mask    = 8'(e);
      tmode   = (e % 3 == 0);
      decoy   = (e % 5 == 2);
      delayed = (e % 16 == 5);
      @(negedge clk);
      cfg_chan_en    = mask;
      cfg_test_mode  = tmode;
      cfg_format_ver = 32'h0300_0000 + 32'(e);
      cfg_module_id  = 32'h0061_0080 ^ 32'(e);
      cfg_run_num    = 32'd1000 + 32'(e);
      cfg_det_type   = 16'(e * 3);
      trg_event_id   = 24'(e * 32'h0001_0203 + 32'h0000_ABCD);
      trg_bcid       = 12'(e * 37);
      trg_type       = 8'(e ^ 8'h5A);
      // R2 trigger number, R3 counter = fragments built so far
      evid = tmode ? 24'(e) : trg_event_id;
      base = exp_n;
      push_exp(32'hB0F0_0000, 1);   // R1
      push_exp(32'hEE12_34EE, 1);
      push_exp(32'h0000_0009, 1);
      push_exp(cfg_format_ver, 1);
      push_exp(cfg_module_id, 1);
      push_exp(cfg_run_num, 1);
      push_exp({8'h00, evid}, tmode ? 3 : 2);
      push_exp({20'h0, trg_bcid}, 1);
      push_exp({24'h0, trg_type}, 1);
      push_exp({16'h0, cfg_det_type}, 1);
      push_exp({8'h80, evid}, tmode ? 3 : 2);
      w = '0;
      for (int c = 0; c < N; c++) begin
         if (mask[c]) begin
            for (int k = 0; k < int'(ch_len(e, c)); k++)
               push_exp({4'(c), 12'(e), 16'(k)}, 4);          // R4 order
            push_exp({4'hA, 4'(c), 8'h00, 16'(ch_len(e, c))},  // R5 / R10
                     (ch_len(e, c) == 0) ? 10 : 5);
            w = w + 16'(ch_len(e, c)) + 16'd1;
         end
      end
      push_exp({16'hF000, w}, 7);   // R7
      push_exp(32'h0000_0000, 6);   // R6
      push_exp(32'h0000_0001, 6);
      push_exp({16'h0, w}, 7);
      push_exp(32'h0000_0001, 6);
      push_exp(32'hE0F0_0000, 6);
      if (!delayed)
         for (int c = 0; c < N; c++) if (mask[c]) load_chan(e, c);
      if (decoy)
         for (int c = 0; c < N; c++) if (!mask[c]) begin
            lmem[c][lwr[c][2:0]] = LW'(1);
            lwr[c] = lwr[c] + 4'd1;
         end
      if (e == 0) begin
         // R9: channels loaded, no trigger yet
         for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk(!out_valid && len_rd == '0 && dat_rd == '0, "R9 idle",
                {31'h0, out_valid}, 32'h0);
         end
      end
      trg_wr = trg_wr + 1;
      if (delayed) begin
         for (int i = 0; i < 40; i++) @(negedge clk);
         // R9: header sent, builder waits at the length FIFO
         chk(got - base == 11 && !out_valid, "R9 length wait", 32'(got - base), 32'd11);
         for (int c = 0; c < N; c++) if (mask[c]) load_chan(e, c);
      end
      while (got < exp_n) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      if (decoy) begin
         for (int c = 0; c < N; c++) if (!mask[c])  // R4 disabled entry untouched
            chk(!len_empty[c], "R4 disabled length kept", {31'h0, len_empty[c]}, 32'h0);
         flush_mask = ~mask;
         @(negedge clk);
         flush_mask = '0;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R11 during reset
      chk(!out_valid && !trg_rd && len_rd == '0 && dat_rd == '0, "R11 in reset",
          {31'h0, out_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && !trg_rd && len_rd == '0 && dat_rd == '0, "R11 after reset",
          {31'h0, out_valid}, 32'h0);
      col_en = 1;
      for (int e = 0; e < 256; e++) run_event(e);
      chk(got == exp_n, "R7 total words", 32'(got), 32'(exp_n));
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule